// File: doc/BRIEF.md
# Level-Sensitive Interrupt Pending Tracker

This block keeps one interrupt-pending bit per source for an interrupt domain that forwards interrupts as messages (MSI delivery) or signals them directly. Each source wire is synchronized, turned into a "rectified" active-high level according to the source's mode, and watched for rising edges of that level. Software set and clear requests, addressed by source number, and an acknowledge-clear pulse that comes back once a forwarded message has been accepted, also update the bits. The pending vector feeds software readback and the forwarding selector.

The central rule concerns level-sensitive sources in message mode. A set is refused while the rectified input is low. Every clear is accepted, whatever the input level. A low rectified input also clears the bit on its own, so a level that drops after it was recorded cannot leave a stale bit that would be forwarded again. Edge-triggered sources keep their usual behaviour. In direct mode a level source's bit simply mirrors its rectified input.

Top module: `lvl_pend_tracker`

## Requirements
- R1: While reset is asserted, and right after it is released, every pending bit reads 0.
- R2: A source input passes through two synchronizer flops and then sets the pending register. A change on the input of a level source in direct mode appears on `pend` after the third rising clock edge, and not after the second.
- R3: The 3-bit mode codes are 0 off, 1 detached, 4 rising edge, 5 falling edge, 6 level high and 7 level low. Codes 2 and 3 are treated as off. For modes 5 and 7 the rectified input is the inverted wire, and for modes 4 and 6 it is the wire as is.
- R4: A rising edge of the rectified input sets pending. For an edge source, a later fall of the input leaves the bit set.
- R5: For edge sources and detached sources, a register set (`reg_set`=1) sets the bit and a register clear (`reg_set`=0) clears it, whatever the input level.
- R6: For a level source in message mode (`msi_mode`=1), a register set takes effect only while the rectified input is high.
- R7: For a level source in message mode, a register clear and an acknowledge clear always clear the bit, including while the rectified input is high.
- R8: For a level source in message mode, a low rectified input forces the bit to 0 on the next edge, even when no acknowledge ever arrives.
- R9: For a level source in direct mode (`msi_mode`=0), the bit follows the rectified input and register set and clear requests are ignored.
- R10: Off and reserved modes hold the bit at 0 and ignore register sets. For detached sources the input wire has no effect.
- R11: Updates that land on the same edge resolve in fixed order: the acknowledge clear beats a trigger, and a trigger beats a register write.
- R12: A level source in message mode with its input held high keeps its bit set until a clear arrives. After an acknowledge it stays clear until a new rising edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| src_in | input | NSRC | Raw source wires, asynchronous to clk |
| src_mode | input | 3*NSRC | Per-source mode code; source i uses bits [3i+2:3i] |
| msi_mode | input | 1 | 1 = message delivery, 0 = direct delivery |
| reg_we | input | 1 | Register-map set or clear request strobe |
| reg_set | input | 1 | 1 = set request, 0 = clear request |
| reg_idx | input | IDXW | Source number of the register request |
| ack_vld | input | 1 | Acknowledge-clear pulse for a forwarded message |
| ack_idx | input | IDXW | Source number of the acknowledge |
| pend | output | NSRC | Pending bits |

## Verification
A wrong pending bit shows at `pend` on the edge after the cause, because every update rule acts in one cycle on the register that drives the port. A stale level bit, or a set that should have been refused, is therefore visible one clock after the write or three clocks after the input changes. A lost trigger or a wrong rectification polarity shows as a missing bit after the third edge. A wrong index decode shows as a bit set at the wrong position, so the bench compares the whole vector for each source in turn, with every other source off.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam logic [2:0] MD_OFF    = 3'd0;
  localparam logic [2:0] MD_DETACH = 3'd1;
  localparam logic [2:0] MD_RISE   = 3'd4;
  localparam logic [2:0] MD_FALL   = 3'd5;
  localparam logic [2:0] MD_HIGH   = 3'd6;
  localparam logic [2:0] MD_LOW    = 3'd7;

  // valid modes: detached, the two edge modes and the two level modes
  function automatic logic md_valid(input logic [2:0] m);
    return (m == MD_DETACH) || m[2];
  endfunction

  function automatic logic md_level(input logic [2:0] m);
    return (m == MD_HIGH) || (m == MD_LOW);
  endfunction

  // modes whose wire is sampled (detached is excluded)
  function automatic logic md_wired(input logic [2:0] m);
    return m[2];
  endfunction

  function automatic logic md_invert(input logic [2:0] m);
    return (m == MD_FALL) || (m == MD_LOW);
  endfunction
endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/lpt_trig.sv
module lpt_trig #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] synced,
  input  logic [W-1:0] wired,
  input  logic [W-1:0] invert,
  output logic [W-1:0] rect,
  output logic [W-1:0] trig
);
  logic [W-1:0] rect_d;
  logic [W-1:0] rect_q;

  always_comb begin
    rect_d = wired & (synced ^ invert);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rect_q <= '0;
    else        rect_q <= rect_d;
  end

  assign rect = rect_d;
  assign trig = rect_d & ~rect_q;

  generate
    for (genvar g = 0; g < W; g++) begin : g_chk
      // R4: a trigger marks one edge only, never two cycles in a row
      assert_trig_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trig[g] |=> !trig[g]);
    end
  endgenerate
endmodule

// File: rtl/lpt_cell.sv
module lpt_cell
  import lpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       msi_mode,
  input  logic       rect,
  input  logic       trig,
  input  logic       reg_hit,
  input  logic       reg_set,
  input  logic       ack_hit,
  output logic       pend
);
  logic valid, lvl, lvl_msi, lvl_dir;
  logic pend_q, pend_d, pend_en;

  always_comb begin
    valid   = md_valid(mode);
    lvl     = md_level(mode);
    lvl_msi = lvl & msi_mode;
    lvl_dir = lvl & ~msi_mode;

    pend_d = pend_q;
    // lowest priority: register-map requests
    if (reg_hit) begin
      if (reg_set) begin
        if (!lvl || (msi_mode && rect)) pend_d = 1'b1;
      end else begin
        if (!lvl || msi_mode) pend_d = 1'b0;
      end
    end
    // source-driven updates
    if (lvl_dir)      pend_d = rect;
    else if (trig)    pend_d = 1'b1;
    if (lvl_msi && !rect) pend_d = 1'b0;
    // highest priority: acknowledge clear
    if (ack_hit)      pend_d = 1'b0;
    if (!valid)       pend_d = 1'b0;
    pend_en = pend_d ^ pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend = pend_q;

  assert_lvl_low_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_msi && !rect) |=> !pend_q);
  assert_ack_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> !pend_q);
  assert_off_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> !pend_q);
  assert_edge_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !lvl && pend_q && !ack_hit && !(reg_hit && !reg_set)) |=> pend_q);
endmodule

// File: rtl/lvl_pend_tracker.sv
module lvl_pend_tracker
  import lpt_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic [3*NSRC-1:0] src_mode,
  input  logic              msi_mode,
  input  logic              reg_we,
  input  logic              reg_set,
  input  logic [IDXW-1:0]   reg_idx,
  input  logic              ack_vld,
  input  logic [IDXW-1:0]   ack_idx,
  output logic [NSRC-1:0]   pend
);
  logic [NSRC-1:0] synced, wired, invert, rect, trig, reg_hit, ack_hit;

  lpt_sync #(.W(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_in), .q(synced)
  );

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      wired[s]   = md_wired(src_mode[3*s +: 3]);
      invert[s]  = md_invert(src_mode[3*s +: 3]);
      reg_hit[s] = reg_we  && (reg_idx == IDXW'(s));
      ack_hit[s] = ack_vld && (ack_idx == IDXW'(s));
    end
  end

  lpt_trig #(.W(NSRC)) u_trig (
    .clk(clk), .rst_n(rst_n), .synced(synced), .wired(wired),
    .invert(invert), .rect(rect), .trig(trig)
  );

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_cell
      lpt_cell u_cell (
        .clk(clk), .rst_n(rst_n), .mode(src_mode[3*g +: 3]),
        .msi_mode(msi_mode), .rect(rect[g]), .trig(trig[g]),
        .reg_hit(reg_hit[g]), .reg_set(reg_set), .ack_hit(ack_hit[g]),
        .pend(pend[g])
      );
    end
  endgenerate
endmodule

// File: tb/sim_lvl_pend_tracker.sv
module sim_lvl_pend_tracker;
  localparam int NSRC = 8;
  localparam int IDXW = 3;
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic [NSRC-1:0] src_in;
  logic [3*NSRC-1:0] src_mode;
  logic msi_mode, reg_we, reg_set, ack_vld;
  logic [IDXW-1:0] reg_idx, ack_idx;
  logic [NSRC-1:0] pend;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  lvl_pend_tracker #(.NSRC(NSRC), .IDXW(IDXW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .src_mode(src_mode),
    .msi_mode(msi_mode), .reg_we(reg_we), .reg_set(reg_set), .reg_idx(reg_idx),
    .ack_vld(ack_vld), .ack_idx(ack_idx), .pend(pend)
  );

  function automatic logic [NSRC-1:0] ev(input bit b, input int i);
    return b ? (NSRC'(1) << i) : '0;
  endfunction

  task automatic check(input string req, input logic [NSRC-1:0] exp);
    n_chk++;
    if (pend !== exp) begin
      n_bad++;
      $display("FAIL %s: pend=%b expected=%b at %0t", req, pend, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input bit s, input int i);
    reg_we = 1'b1; reg_set = s; reg_idx = IDXW'(i);
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic ack(input int i);
    ack_vld = 1'b1; ack_idx = IDXW'(i);
    @(posedge clk); @(negedge clk);
    ack_vld = 1'b0;
  endtask

  task automatic setmode(input int i, input logic [2:0] m);
    src_mode[3*i +: 3] = m;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; src_in = '0; src_mode = '0; msi_mode = 1'b1;
    reg_we = 0; reg_set = 0; reg_idx = '0; ack_vld = 0; ack_idx = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", '0);

    for (int i = 0; i < NSRC; i++) begin
      // level high, message mode
      msi_mode = 1'b1; setmode(i, 3'd6); src_in[i] = 1'b0; settle();
      check("R8 level low input", '0);
      wr(1, i); check("R6 set refused while low", '0);
      src_in[i] = 1'b1; settle(); check("R4 level rising sets", ev(1, i));
      repeat (10) @(negedge clk); check("R12 held high stays set", ev(1, i));
      wr(0, i); check("R7 reg clear while high", '0);
      wr(1, i); check("R6 set accepted while high", ev(1, i));
      ack(i); check("R7 ack clear while high", '0);
      settle(); check("R12 no retrigger after ack", '0);
      wr(1, i); check("R6 set again", ev(1, i));
      src_in[i] = 1'b0; settle(); check("R8 input fall clears", '0);
      ack(i); check("R7 ack while low", '0);
      // register set and low input in the same cycle
      wr(1, i); check("R8 low beats set", '0);

      // level low, message mode
      src_in[i] = 1'b1; setmode(i, 3'd7); settle(); check("R3 level-low high wire", '0);
      src_in[i] = 1'b0; settle(); check("R3 level-low low wire sets", ev(1, i));
      src_in[i] = 1'b1; settle(); check("R3 level-low release clears", '0);
      setmode(i, 3'd0); src_in[i] = 1'b0; settle();

      // level high, direct mode, latency
      msi_mode = 1'b0; setmode(i, 3'd6); settle();
      src_in[i] = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check("R2 not yet after two edges", '0);
      @(posedge clk); @(negedge clk);
      check("R2 visible after third edge", ev(1, i));
      wr(0, i); check("R9 clear ignored in direct", ev(1, i));
      src_in[i] = 1'b0; settle(); check("R9 follows input low", '0);
      wr(1, i); check("R9 set ignored in direct", '0);
      setmode(i, 3'd0); msi_mode = 1'b1; settle();

      // rising edge
      setmode(i, 3'd4); settle(); check("R4 edge idle", '0);
      src_in[i] = 1'b1; settle(); check("R4 edge sets", ev(1, i));
      src_in[i] = 1'b0; settle(); check("R4 edge holds after fall", ev(1, i));
      wr(0, i); check("R5 edge reg clear", '0);
      wr(1, i); check("R5 edge reg set while low", ev(1, i));
      ack(i); check("R7 edge ack clear", '0);
      // trigger and register clear on the same edge
      src_in[i] = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      reg_we = 1'b1; reg_set = 1'b0; reg_idx = IDXW'(i);
      @(posedge clk); @(negedge clk); reg_we = 1'b0;
      check("R11 trigger beats register clear", ev(1, i));
      src_in[i] = 1'b0; settle(); wr(0, i);
      // trigger and ack on the same edge
      src_in[i] = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      ack_vld = 1'b1; ack_idx = IDXW'(i);
      @(posedge clk); @(negedge clk); ack_vld = 1'b0;
      check("R11 ack beats trigger", '0);
      // register set and ack on the same edge
      reg_we = 1'b1; reg_set = 1'b1; reg_idx = IDXW'(i);
      ack_vld = 1'b1; ack_idx = IDXW'(i);
      @(posedge clk); @(negedge clk); reg_we = 1'b0; ack_vld = 1'b0;
      check("R11 ack beats register set", '0);

      // falling edge
      setmode(i, 3'd5); settle(); check("R3 falling idle high", '0);
      src_in[i] = 1'b0; settle(); check("R3 falling edge sets", ev(1, i));
      setmode(i, 3'd0); @(posedge clk); @(negedge clk);
      check("R10 off clears", '0);

      // detached
      setmode(i, 3'd1); src_in[i] = 1'b1; settle(); check("R10 detached ignores wire", '0);
      wr(1, i); check("R5 detached reg set", ev(1, i));
      src_in[i] = 1'b0; settle(); check("R10 detached wire no effect", ev(1, i));
      wr(0, i); check("R5 detached reg clear", '0);

      // reserved and off
      setmode(i, 3'd2); src_in[i] = 1'b1; settle(); wr(1, i);
      check("R10 reserved ignores set", '0);
      setmode(i, 3'd0); wr(1, i); check("R10 off ignores set", '0);
      src_in[i] = 1'b0; settle();
    end
    finish_run();
  end
endmodule